// File: doc/BRIEF.md
# Peripheral Clock Enable Divider

This block turns the CPU clock into a periodic clock-enable strobe for peripheral logic. The peripheral logic stays on the CPU clock and does work only in the cycles where the strobe is high. No second clock is generated and nothing is gated. The rate is chosen by a 2-bit ratio code that software writes through a single-cycle write strobe. The code in force can always be read back.

The code-to-ratio mapping is not monotonic. Code 00 gives one strobe every fourth CPU cycle, code 10 gives one every second cycle, and code 01 keeps the strobe high on every cycle. Code 11 is reserved: a write of it is dropped, and both the stored code and the running phase carry on as if no write had happened. Any accepted write restarts the internal phase counter, so the new ratio starts from a clean period boundary.

The write port is a plain strobe with no back-pressure. The block accepts a write on every cycle in which the strobe is high. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pclk_strobe_gen`

## Requirements
- R1: After reset (asynchronous, active low) the readback shows 00 and the divide-by-4 ratio is in force. The strobe is low while reset is held. After release it is high in the 3rd, 7th, 11th... cycles, counted from the first rising edge after release.
- R2: While the stored code is 01, the strobe is high in every cycle.
- R3: While the stored code is 10, the strobe is high in exactly one cycle of every two. After a write of 10 it is high in cycles 2, 4, 6... after the write edge.
- R4: While the stored code is 00, the strobe is high in exactly one cycle of every four. After a write of 00 it is high in cycles 4, 8... after the write edge.
- R5: A write of code 11 has no effect. The readback keeps its previous value, and the strobe keeps the phase it had before the write, without restarting.
- R6: An accepted write of 00, 01 or 10 restarts the phase counter, even when it repeats the stored code. Under a divided ratio the first strobe therefore comes a full period after the write edge, and the strobe is low in every earlier cycle.
- R7: The readback output always shows the code in force, and never shows 11.
- R8: An accepted write is visible on the readback in the first cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the ratio code, sampled on the rising edge |
| wr_data_i | input | 2 | Ratio code: 00 divide by 4, 01 divide by 1, 10 divide by 2, 11 reserved |
| rd_data_o | output | 2 | Ratio code currently in force |
| pclk_en_o | output | 1 | Peripheral clock-enable strobe |

## Verification
The assertions assume that `wr_data_i` holds a known value whenever `wr_en_i` is high. They also assume that `wr_en_i` is a synchronous, single-cycle-per-write strobe that is never driven while reset is asserted. The stimulus changes every input only on falling clock edges and holds `wr_en_i` high for exactly one rising edge per write. It releases reset on a falling edge so that no write coincides with it. The vectors order the reserved writes right after fresh writes of 10 and 00. This lets the expected strobe phase be derived from the earlier write edge and tell a dropped write apart from a restart.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  // Ratio code as written by software and shown on readback.
  typedef enum logic [1:0] {
    SEL_QUARTER = 2'b00,
    SEL_FULL    = 2'b01,
    SEL_HALF    = 2'b10,
    SEL_RSVD    = 2'b11
  } div_sel_e;

endpackage

// File: rtl/div_sel_reg.sv
module div_sel_reg
  import pclk_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  output div_sel_e   sel_o,
  output logic       restart_o
);

  div_sel_e sel_q;
  logic     accept;

  // Reserved code is dropped at the door; every other write is taken.
  assign accept = wr_en_i && (wr_data_i != SEL_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_QUARTER;
    end else if (accept) begin
      sel_q <= div_sel_e'(wr_data_i);
    end
  end

  assign sel_o     = sel_q;
  assign restart_o = accept;

  // R5: a reserved write leaves the stored code untouched
  p_rsvd_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == 2'b11) |=> $stable(sel_q));

  // R8: an accepted write shows up on the next cycle
  p_load_visible_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i != 2'b11) |=> (sel_q == $past(wr_data_i)));

  // R7: the stored code never takes the reserved value
  p_no_rsvd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != SEL_RSVD));

endmodule

// File: rtl/pulse_counter.sv
module pulse_counter
  import pclk_div_pkg::*;
#(
  parameter int QUARTER_DIV = 4,
  parameter int HALF_DIV    = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  div_sel_e sel_i,
  input  logic     restart_i,
  output logic     en_o
);

  localparam int CNT_W = (QUARTER_DIV > 1) ? $clog2(QUARTER_DIV) : 1;
  localparam int PER_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [PER_W-1:0] period;
  logic             last;

  always_comb begin
    unique case (sel_i)
      SEL_QUARTER: period = PER_W'(QUARTER_DIV);
      SEL_HALF:    period = PER_W'(HALF_DIV);
      default:     period = PER_W'(1);
    endcase
  end

  assign last = ({1'b0, cnt_q} == (period - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o = last;

  // R2: full rate keeps the strobe high
  p_full_every_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_FULL) |-> en_o);

  // R3: at half rate a strobe is followed by a quiet cycle
  p_half_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_HALF && en_o && !restart_i) |=> !en_o);

  // R4: at quarter rate a strobe is followed by a quiet cycle
  p_quarter_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_QUARTER && en_o && !restart_i) |=> !en_o);

  // R6: an accepted write brings the phase back to its start
  p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));

  // R6: the phase stays inside the selected period
  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} < period));

endmodule

// File: rtl/pclk_strobe_gen.sv
module pclk_strobe_gen
  import pclk_div_pkg::*;
#(
  parameter int QUARTER_DIV = 4,
  parameter int HALF_DIV    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  output logic [1:0] rd_data_o,
  output logic       pclk_en_o
);

  div_sel_e sel;
  logic     restart;

  div_sel_reg u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .sel_o     (sel),
    .restart_o (restart)
  );

  pulse_counter #(
    .QUARTER_DIV (QUARTER_DIV),
    .HALF_DIV    (HALF_DIV)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .restart_i (restart),
    .en_o      (pclk_en_o)
  );

  assign rd_data_o = sel;

  // R7: readback never reports the reserved code
  p_rd_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o != 2'b11));

endmodule

// File: tb/pclk_strobe_gen_tb.sv
module pclk_strobe_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic [1:0] rd_data;
  logic       pclk_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pclk_strobe_gen u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .pclk_en_o (pclk_en)
  );

  // Vector: {code written, readback expected, strobe pattern for cycles 1..8 after the write edge (bit 0 = cycle 1)}
  localparam int NVEC = 10;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b01, 2'b01, 8'b1111_1111},  // R2 R8
    {2'b10, 2'b10, 8'b1010_1010},  // R3 R6
    {2'b11, 2'b10, 8'b1010_1010},  // R5 dropped after 10
    {2'b00, 2'b00, 8'b1000_1000},  // R4 R6
    {2'b11, 2'b00, 8'b0010_0010},  // R5 phase continues, no restart
    {2'b10, 2'b10, 8'b1010_1010},  // R3
    {2'b00, 2'b00, 8'b1000_1000},  // R6 restart from half
    {2'b11, 2'b00, 8'b0010_0010},  // R5
    {2'b01, 2'b01, 8'b1111_1111},  // R2
    {2'b11, 2'b01, 8'b1111_1111}   // R5 R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Write a code; on return the bench sits at the falling edge of cycle 1 after the write edge.
  task automatic do_write(input logic [1:0] code);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = code;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  initial begin
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    check("R1 rd in reset", {6'd0, rd_data}, 8'h00);
    check("R1 strobe in reset", {7'd0, pclk_en}, 8'h00);
    rst_n = 1'b1;
    // R1 R4: pulses in cycles 3 and 7 after release
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R1 post-reset strobe", {7'd0, pclk_en}, {7'd0, (k == 3 || k == 7)});
    end
    check("R1 rd after reset", {6'd0, rd_data}, 8'h00);

    // Vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] seen;
      do_write(VEC[v][11:10]);
      check("R7 R8 R5 readback", {6'd0, rd_data}, {6'd0, VEC[v][9:8]});
      seen = '0;
      for (int i = 0; i < 8; i++) begin
        seen[i] = pclk_en;
        @(negedge clk);
      end
      check("R2 R3 R4 R5 R6 strobe pattern", seen, VEC[v][7:0]);
    end

    // R6: repeating the same code restarts the phase
    do_write(2'b00);
    repeat (5) @(negedge clk);            // now at cycle 6
    do_write(2'b00);                      // counter would be mid-period without restart
    begin
      logic [7:0] seen;
      seen = '0;
      for (int i = 0; i < 8; i++) begin
        seen[i] = pclk_en;
        @(negedge clk);
      end
      check("R6 same-code restart", seen, 8'b1000_1000);
    end

    // R1: reset in the middle of half-rate operation returns to quarter rate
    do_write(2'b10);
    rst_n = 1'b0;
    #1;
    check("R1 async reset readback", {6'd0, rd_data}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      logic [7:0] seen;
      seen = '0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        seen[i] = pclk_en;
      end
      check("R1 quarter rate after re-reset", seen, 8'b0100_0100);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule